// File: doc/BRIEF.md
# Redundant Speed Trip Voter with Timed Degraded Mode

This block decides, from three redundant speed readings, whether a rotating machine must be shut down. Each reading comes with a validity bit from an upstream diagnostic stage. On every evaluation strobe the block counts the valid channels whose speed lies above a trip limit. When at least two of them do, it latches a trip.

Losing a single channel does not stop the protection. When exactly two channels are valid the voter moves to a degraded state and raises an alarm once. It starts a seconds counter from the one-second tick and keeps voting on the valid channels only. Degraded operation has a maximum allowed duration. If that duration is exceeded, or if fewer than two channels remain valid, the block forces a trip and raises a distinct alarm code. A repair request returns the block to normal operation, but only while all three channels report valid. A latched trip clears only through reset.

Top module: `tmr_trip_voter`

## Requirements
- R1: After reset the status output is NORMAL (0), trip is low and alarm_stb is low.
- R2: A channel counts as above the limit only when its speed is strictly greater than TRIP_LIMIT (default 5000). A speed equal to the limit does not count.
- R3: On a strobe in which at least two valid channels are above the limit, trip rises in the next cycle, status becomes TRIPPED (2), and alarm_stb pulses with code OVERSPEED (4).
- R4: Channels whose valid bit is low are excluded from the above-limit count, whatever their speed.
- R5: On a strobe with fewer than two valid channels, the block trips in the next cycle with alarm code LOST (2), regardless of the speeds. This check has priority over the timeout and the vote.
- R6: On the first strobe with exactly two valid channels while in NORMAL, and with no trip decided, status becomes DEGRADED (1) and alarm_stb pulses once with code DEGRADED (1). Later strobes in DEGRADED raise no further degraded alarm.
- R7: In DEGRADED each sec_tick adds one second to the elapsed time. A strobe while the elapsed time is strictly greater than MAX_DEGRADED_S (default 86400) trips with code TIMEOUT (3), with priority over the vote. An elapsed time equal to the maximum does not trip.
- R8: Once tripped, trip and the TRIPPED status hold until reset. Strobes, ticks and repair requests then cause no alarm and no status change.
- R9: A repair request while DEGRADED and all three valid bits high returns status to NORMAL and clears the elapsed time, so a later entry into DEGRADED restarts the count from zero. A repair request with any valid bit low has no effect.
- R10: Without sample_stb, speed and valid inputs cause no trip, no alarm and no status change. All outputs change one clock after the causing input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only way to clear a trip |
| sample_stb | input | 1 | Evaluate the current speeds and valid mask this cycle |
| sec_tick | input | 1 | One-cycle pulse once per second |
| repair | input | 1 | Request to leave the degraded state |
| ch_valid | input | 3 | Per-channel validity from diagnostics |
| ch_speed | input | 3 x SPEED_W | Per-channel speed reading in rpm |
| trip | output | 1 | Latched shutdown demand |
| status | output | 2 | 0 NORMAL, 1 DEGRADED, 2 TRIPPED |
| alarm_stb | output | 1 | One-cycle pulse marking a new alarm |
| alarm_code | output | 3 | 0 none, 1 DEGRADED, 2 LOST, 3 TIMEOUT, 4 OVERSPEED |

## Verification
The assertions check on every cycle that a trip stays latched and that the status encoding stays legal. They also check that a strobe with too few valid channels, an overspeed vote in normal operation, or an expired dwell time leads to the right trip and code in the next cycle. The elapsed counter is checked to saturate and to restart from zero on clear. Some behaviour only the bench scenarios can show, because it depends on sequences: the limit boundary at exactly 5000 rpm, a single degraded alarm across repeated strobes, and the dwell boundary at exactly the maximum against one second past it. The same holds for an ignored repair with a channel still invalid, and for the timer restarting after a repair and a fresh degradation.

// File: rtl/tmr_voter_pkg.sv
package tmr_voter_pkg;

    localparam int unsigned NUM_CH = 3;
    localparam int unsigned QUORUM = 2;

    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_DEGRADED = 2'd1,
        ST_TRIPPED  = 2'd2
    } vstate_e;

    typedef enum logic [2:0] {
        AL_NONE      = 3'd0,
        AL_DEGRADED  = 3'd1,
        AL_LOST      = 3'd2,
        AL_TIMEOUT   = 3'd3,
        AL_OVERSPEED = 3'd4
    } alarm_e;

endpackage

// File: rtl/tmr_vote_count.sv
module tmr_vote_count #(
    parameter int unsigned NCH        = 3,
    parameter int unsigned SPEED_W    = 16,
    parameter int unsigned TRIP_LIMIT = 5000,
    localparam int unsigned CNT_W     = $clog2(NCH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCH-1:0]               valid,
    input  logic [NCH-1:0][SPEED_W-1:0]  speed,
    output logic [CNT_W-1:0]             n_valid,
    output logic [CNT_W-1:0]             n_above
);

    localparam logic [SPEED_W-1:0] LIMIT_V = SPEED_W'(TRIP_LIMIT);

    logic [NCH-1:0] above;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign above[g] = valid[g] && (speed[g] > LIMIT_V);
    end

    always_comb begin
        n_valid = '0;
        n_above = '0;
        for (int i = 0; i < NCH; i++) begin
            n_valid = n_valid + CNT_W'(valid[i]);
            n_above = n_above + CNT_W'(above[i]);
        end
    end

    // invalid channels never contribute to the vote
    assert_above_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        n_above <= n_valid);

endmodule

// File: rtl/tmr_dwell_timer.sv
module tmr_dwell_timer #(
    parameter int unsigned MAX_S  = 86400,
    localparam int unsigned TW    = $clog2(MAX_S + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    output logic          over
);

    localparam logic [TW-1:0] SAT_V = TW'(MAX_S + 1);
    localparam logic [TW-1:0] MAX_V = TW'(MAX_S);

    logic [TW-1:0] elapsed_d, elapsed_q;

    always_comb begin
        elapsed_d = elapsed_q;
        if (clear) begin
            elapsed_d = '0;
        end else if (run && tick && (elapsed_q != SAT_V)) begin
            elapsed_d = elapsed_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elapsed_q <= '0;
        else        elapsed_q <= elapsed_d;
    end

    assign over = elapsed_q > MAX_V;

    assert_elapsed_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed_q <= SAT_V);

    assert_clear_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (elapsed_q == '0));

endmodule

// File: rtl/tmr_trip_voter.sv
module tmr_trip_voter
    import tmr_voter_pkg::*;
#(
    parameter int unsigned SPEED_W        = 16,
    parameter int unsigned TRIP_LIMIT     = 5000,
    parameter int unsigned MAX_DEGRADED_S = 86400
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sample_stb,
    input  logic                            sec_tick,
    input  logic                            repair,
    input  logic [2:0]                      ch_valid,
    input  logic [2:0][SPEED_W-1:0]         ch_speed,
    output logic                            trip,
    output logic [1:0]                      status,
    output logic                            alarm_stb,
    output logic [2:0]                      alarm_code
);

    localparam int unsigned CNT_W = $clog2(NUM_CH + 1);
    localparam logic [CNT_W-1:0] QUORUM_V = CNT_W'(QUORUM);

    typedef struct packed {
        vstate_e st;
        logic    a_stb;
        alarm_e  a_code;
    } vreg_t;

    vreg_t r_d, r_q;

    logic [CNT_W-1:0] n_valid, n_above;
    logic             over;
    logic             tmr_clear;
    logic             repaired;

    tmr_vote_count #(
        .NCH        (NUM_CH),
        .SPEED_W    (SPEED_W),
        .TRIP_LIMIT (TRIP_LIMIT)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (ch_valid),
        .speed   (ch_speed),
        .n_valid (n_valid),
        .n_above (n_above)
    );

    tmr_dwell_timer #(
        .MAX_S (MAX_DEGRADED_S)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .run   (r_q.st == ST_DEGRADED),
        .tick  (sec_tick),
        .over  (over)
    );

    assign repaired = (r_q.st == ST_DEGRADED) && repair && (&ch_valid);

    always_comb begin
        vstate_e eff;
        r_d       = r_q;
        r_d.a_stb = 1'b0;
        tmr_clear = 1'b0;
        eff       = r_q.st;
        if (r_q.st != ST_TRIPPED) begin
            if (repaired) begin
                eff       = ST_NORMAL;
                tmr_clear = 1'b1;
            end
            r_d.st = eff;
            if (sample_stb) begin
                if (n_valid < QUORUM_V) begin
                    r_d.st     = ST_TRIPPED;
                    r_d.a_stb  = 1'b1;
                    r_d.a_code = AL_LOST;
                end else if ((eff == ST_DEGRADED) && over) begin
                    r_d.st     = ST_TRIPPED;
                    r_d.a_stb  = 1'b1;
                    r_d.a_code = AL_TIMEOUT;
                end else if (n_above >= QUORUM_V) begin
                    r_d.st     = ST_TRIPPED;
                    r_d.a_stb  = 1'b1;
                    r_d.a_code = AL_OVERSPEED;
                end else if ((n_valid == QUORUM_V) && (eff == ST_NORMAL)) begin
                    r_d.st     = ST_DEGRADED;
                    r_d.a_stb  = 1'b1;
                    r_d.a_code = AL_DEGRADED;
                    tmr_clear  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_NORMAL;
            r_q.a_stb  <= 1'b0;
            r_q.a_code <= AL_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign trip       = (r_q.st == ST_TRIPPED);
    assign status     = r_q.st;
    assign alarm_stb  = r_q.a_stb;
    assign alarm_code = r_q.a_code;

    assert_trip_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (trip && !alarm_stb));

    assert_status_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);

    assert_lost_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !trip && ($countones(ch_valid) < 2))
        |=> (trip && alarm_stb && (alarm_code == AL_LOST)));

    assert_vote_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && (status == ST_NORMAL) && (&ch_valid) && (n_above >= QUORUM_V))
        |=> (trip && alarm_stb && (alarm_code == AL_OVERSPEED)));

    assert_timeout_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && (status == ST_DEGRADED) && over && !repaired
         && ($countones(ch_valid) >= 2))
        |=> (trip && (alarm_code == AL_TIMEOUT)));

    assert_degraded_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && (status == ST_NORMAL) && ($countones(ch_valid) == 2)
         && (n_above < QUORUM_V))
        |=> ((status == ST_DEGRADED) && alarm_stb && (alarm_code == AL_DEGRADED)));

    assert_no_strobe_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_stb && !trip) |=> (!alarm_stb && !trip));

endmodule

// File: tb/tmr_trip_voter_tb.sv
module tmr_trip_voter_tb_top;

    localparam int SPEED_W = 16;
    localparam int LIMIT   = 5000;
    localparam int MAXS    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0, sec_tick = 1'b0, repair = 1'b0;
    logic [2:0] ch_valid = 3'b111;
    logic [2:0][SPEED_W-1:0] ch_speed = '0;
    logic trip, alarm_stb;
    logic [1:0] status;
    logic [2:0] alarm_code;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_en = 1'b0;
    string cur_req = "R1";

    int m_state = 0, m_el = 0, m_code = 0;
    bit m_stb = 1'b0;

    always #5 clk = ~clk;

    tmr_trip_voter #(
        .SPEED_W        (SPEED_W),
        .TRIP_LIMIT     (LIMIT),
        .MAX_DEGRADED_S (MAXS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .sec_tick(sec_tick),
        .repair(repair), .ch_valid(ch_valid), .ch_speed(ch_speed),
        .trip(trip), .status(status), .alarm_stb(alarm_stb), .alarm_code(alarm_code)
    );

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_el = 0; m_code = 0; m_stb = 1'b0;
        end else begin
            int old_el, nv, na;
            old_el = m_el;
            m_stb = 1'b0;
            if (m_state != 2) begin
                if (m_state == 1 && repair && ch_valid == 3'b111) begin
                    m_state = 0; m_el = 0;
                end else if (m_state == 1 && sec_tick && m_el < MAXS + 1) begin
                    m_el = m_el + 1;
                end
                if (sample_stb) begin
                    nv = 0; na = 0;
                    for (int i = 0; i < 3; i++) begin
                        if (ch_valid[i]) begin
                            nv++;
                            if (int'(ch_speed[i]) > LIMIT) na++;
                        end
                    end
                    if (nv < 2) begin
                        m_state = 2; m_stb = 1'b1; m_code = 2;
                    end else if (m_state == 1 && old_el > MAXS) begin
                        m_state = 2; m_stb = 1'b1; m_code = 3;
                    end else if (na >= 2) begin
                        m_state = 2; m_stb = 1'b1; m_code = 4;
                    end else if (nv == 2 && m_state == 0) begin
                        m_state = 1; m_stb = 1'b1; m_code = 1; m_el = 0;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            check(int'(status) == m_state, cur_req, "status", int'(status), m_state);
            check(trip == (m_state == 2), cur_req, "trip", int'(trip), int'(m_state == 2));
            check(alarm_stb == m_stb, cur_req, "alarm_stb", int'(alarm_stb), int'(m_stb));
            check(int'(alarm_code) == m_code, cur_req, "alarm_code", int'(alarm_code), m_code);
        end
    end

    // inputs change at negedge; one step = one clock
    task automatic step(input bit stb, input bit tk, input bit rp, input logic [2:0] v,
                        input int s0, input int s1, input int s2);
        sample_stb = stb; sec_tick = tk; repair = rp; ch_valid = v;
        ch_speed[0] = SPEED_W'(s0); ch_speed[1] = SPEED_W'(s1); ch_speed[2] = SPEED_W'(s2);
        @(negedge clk);
        sample_stb = 1'b0; sec_tick = 1'b0; repair = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_now(input string req, input int st, input bit stb, input int code);
        check(int'(status) == st, req, "direct status", int'(status), st);
        check(alarm_stb == stb, req, "direct alarm_stb", int'(alarm_stb), int'(stb));
        if (stb) check(int'(alarm_code) == code, req, "direct code", int'(alarm_code), code);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        cmp_en = 1'b1;
        cur_req = "R1";
        expect_now("R1", 0, 1'b0, 0);
        check(trip == 1'b0, "R1", "reset trip", int'(trip), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: no strobe, high speeds ignored
        cur_req = "R10";
        step(0, 0, 0, 3'b111, 9000, 9000, 9000);
        step(0, 0, 0, 3'b001, 9000, 9000, 9000);
        expect_now("R10", 0, 1'b0, 0);

        // R2: exactly at limit does not count
        cur_req = "R2";
        step(1, 0, 0, 3'b111, 5000, 5000, 6000);
        expect_now("R2", 0, 1'b0, 0);

        // R3: two strictly above
        cur_req = "R3";
        step(1, 0, 0, 3'b111, 5001, 0, 5001);
        expect_now("R3", 2, 1'b1, 4);
        do_reset();

        // R5: one valid channel, low speeds
        cur_req = "R5";
        step(1, 0, 0, 3'b010, 100, 100, 100);
        expect_now("R5", 2, 1'b1, 2);

        // R8: strobes and repair ignored after trip
        cur_req = "R8";
        step(1, 1, 1, 3'b000, 9000, 9000, 9000);
        step(1, 0, 1, 3'b111, 100, 100, 100);
        expect_now("R8", 2, 1'b0, 0);
        do_reset();
        cur_req = "R1";
        expect_now("R1", 0, 1'b0, 0);

        // R6: degraded entry, alarm once
        cur_req = "R6";
        step(1, 0, 0, 3'b101, 100, 100, 100);
        expect_now("R6", 1, 1'b1, 1);
        step(1, 0, 0, 3'b101, 100, 100, 100);
        expect_now("R6", 1, 1'b0, 0);

        // R4: invalid high channel excluded
        cur_req = "R4";
        step(1, 0, 0, 3'b101, 6000, 9000, 100);
        expect_now("R4", 1, 1'b0, 0);

        // R9: repair with invalid channel ignored
        cur_req = "R9";
        step(0, 0, 1, 3'b101, 100, 100, 100);
        expect_now("R9", 1, 1'b0, 0);

        // R7: exactly MAXS seconds: no trip
        cur_req = "R7";
        for (int k = 0; k < MAXS; k++) step(0, 1, 0, 3'b101, 100, 100, 100);
        step(1, 0, 0, 3'b101, 100, 100, 100);
        expect_now("R7", 1, 1'b0, 0);

        // R9: repair restores normal, timer cleared
        cur_req = "R9";
        step(0, 0, 1, 3'b111, 100, 100, 100);
        expect_now("R9", 0, 1'b0, 0);
        step(1, 0, 0, 3'b011, 100, 100, 100);
        expect_now("R9", 1, 1'b1, 1);
        for (int k = 0; k < MAXS; k++) step(0, 1, 0, 3'b011, 100, 100, 100);
        step(1, 0, 0, 3'b011, 100, 100, 100);
        expect_now("R9", 1, 1'b0, 0);

        // R7: one second past maximum, vote would not trip
        cur_req = "R7";
        step(0, 1, 0, 3'b011, 100, 100, 100);
        step(1, 0, 0, 3'b111, 100, 100, 100);
        expect_now("R7", 2, 1'b1, 3);
        do_reset();

        // R3 in degraded mode: two valid channels above limit
        cur_req = "R3";
        step(1, 0, 0, 3'b110, 100, 200, 300);
        step(1, 1, 0, 3'b110, 100, 7000, 7000);
        expect_now("R3", 2, 1'b1, 4);
        do_reset();

        // R5 priority over overspeed with a single valid channel high
        cur_req = "R5";
        step(1, 0, 0, 3'b100, 9000, 9000, 9000);
        expect_now("R5", 2, 1'b1, 2);

        @(negedge clk);
        cmp_en = 1'b0;
        finish_run();
    end

endmodule